// File: doc/BRIEF.md
# Dual-Channel Multi-Lane Sample Serializer

This block takes a pair of simultaneously captured sample words, one per channel, and shifts each word out on a group of four data lanes per channel, using one, two or four of them at a time. A two-bit lane-mode input picks the lane count. Along with the data, the block drives a forwarded data clock and a frame marker. The data clock lets a receiver sample each bit slot, and the frame marker lets it find where each word begins. All logic runs on a single fast clock at single data rate. Each bit slot lasts two fast-clock cycles, and the forwarded data clock rises in the middle of the slot.

A sample pair is offered with a one-cycle valid strobe, normally once per conversion. The lane mode is captured together with the pair, so a word is never sent in a mix of modes. A new pair may arrive in the last cycle of the word in flight, and then the next word follows with no gap. A pair that arrives any earlier is dropped, and a sticky overrun flag records the loss.

Top module: `dual_lane_serializer`

## Requirements
- R1: After a synchronous active-low reset, all eight lanes, the frame output, the data clock output and the overrun flag are 0.
- R2: When the block is idle, a valid strobe captures both words at that clock edge. From the next cycle on, the outputs present slot 0 of the new word. Channel 0 is bits [WORD_W-1:0] of the packed sample input. Channel 1 is the next WORD_W bits.
- R3: The lane count L comes from the lane mode captured with the word: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4, and the reserved code 2'b11 gives 1. The word has WORD_W/L slots. In slot k, lane j (j < L) carries word bit WORD_W-1-L*k-j, so the MSB goes first on lane A. The lanes of channel c are bits [4c+3:4c] of the lane output, with lane A at the lowest bit of the group.
- R4: Lanes with index j >= L carry 0 throughout a word, and every lane is 0 while the block is idle.
- R5: The frame output is 1 during slots 0 to WORD_W/(2L)-1 of a word and 0 in the remaining slots and while idle. Its rising edge therefore marks the MSB slot.
- R6: Each slot lasts two clock cycles. The data clock output is 0 in the first cycle of a slot and 1 in the second, and it is 0 while idle.
- R7: A change on the lane-mode input while a word is in flight has no effect on that word. The mode is sampled only when a word is accepted.
- R8: A valid strobe in the last cycle of a word is accepted. Slot 0 of the new word follows in the very next cycle, using the mode presented with the strobe.
- R9: A valid strobe while a word is in flight and before its last cycle is dropped. The word in flight continues unchanged, and the overrun output goes to 1 in the next cycle and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe offering a new sample pair |
| smp_words | input | NUM_CH*WORD_W | Packed sample words, channel 0 in the low bits |
| lane_mode | input | 2 | Lane-count select, sampled on acceptance |
| lanes_out | output | NUM_CH*LANES | Serial data lanes, four per channel |
| dclk_out | output | 1 | Forwarded data clock, high in the second half of each slot |
| frame_out | output | 1 | Word-boundary marker, high for the first half of the word |
| overrun | output | 1 | Sticky flag set when a sample pair is dropped |

## Verification
Two functions can land on the same clock edge. A word can end while a new pair is accepted, and a pair can be dropped while the lane-mode input is changing under a word in flight. The bench provokes the first by raising the strobe exactly in the final cycle of a word. It expects slot 0 of the new word, in the new mode, in the next cycle with no idle gap. It provokes the second by raising a strobe with random data, and at other cycles changing the mode, partway through a word. It then checks every remaining slot of that word against the originally captured data and mode, and checks that the overrun flag rises one cycle after the dropped strobe.

// File: rtl/lane_ser_pkg.sv
// Package: shared lane-mode encoding and the lane-count decode used by the
// sequencer and by the per-channel shifters.
package lane_ser_pkg;

    // Lane-mode codes; the reserved code behaves as one lane.
    typedef enum logic [1:0] {
        LM_X1   = 2'b00,
        LM_X2   = 2'b01,
        LM_X4   = 2'b10,
        LM_RSVD = 2'b11
    } lane_mode_e;

    // Number of active lanes selected by a mode code.
    function automatic logic [2:0] lanes_of(lane_mode_e m);
        case (m)
            LM_X2:   lanes_of = 3'd2;
            LM_X4:   lanes_of = 3'd4;
            default: lanes_of = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/lser_sequencer.sv
// Module: lser_sequencer
// Slot and phase sequencer shared by all channels. It accepts sample pairs,
// latches the lane mode per word, counts two-cycle bit slots, and produces
// the forwarded data clock, the frame marker and the sticky overrun flag.
// Assumes WORD_W is a multiple of 4 and that the lane set is {1, 2, 4}.
module lser_sequencer
    import lane_ser_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic [1:0] mode_in,
    output logic       load_o,
    output logic       shift_o,
    output logic       active_o,
    output logic [2:0] lanes_o,
    output logic       dclk_o,
    output logic       frame_o,
    output logic       overrun_o
);

    localparam int SLOT_W = $clog2(WORD_W);
    localparam logic [SLOT_W-1:0] LAST_X1 = SLOT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] LAST_X2 = SLOT_W'(WORD_W / 2 - 1);
    localparam logic [SLOT_W-1:0] LAST_X4 = SLOT_W'(WORD_W / 4 - 1);
    localparam logic [SLOT_W-1:0] HALF_X1 = SLOT_W'(WORD_W / 2);
    localparam logic [SLOT_W-1:0] HALF_X2 = SLOT_W'(WORD_W / 4);
    localparam logic [SLOT_W-1:0] HALF_X4 = SLOT_W'(WORD_W / 8);

    logic              busy_q;
    logic              phase_q;
    logic [SLOT_W-1:0] slot_q;
    lane_mode_e        mode_q;
    logic              ovr_q;

    logic [SLOT_W-1:0] last_slot;
    logic [SLOT_W-1:0] half_slot;
    logic              at_end;
    logic              accept;
    logic              drop;

    // Per-mode last slot index and the first slot where the frame goes low.
    always_comb begin
        case (mode_q)
            LM_X2: begin
                last_slot = LAST_X2;
                half_slot = HALF_X2;
            end
            LM_X4: begin
                last_slot = LAST_X4;
                half_slot = HALF_X4;
            end
            default: begin
                last_slot = LAST_X1;
                half_slot = HALF_X1;
            end
        endcase
    end

    // Word-boundary, acceptance and drop decisions.
    always_comb begin
        at_end = busy_q && phase_q && (slot_q == last_slot);
        accept = smp_valid && (!busy_q || at_end);
        drop   = smp_valid && busy_q && !at_end;
    end

    // Slot/phase counters and the per-word mode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            slot_q  <= '0;
            mode_q  <= LM_X1;
        end else if (accept) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            slot_q  <= '0;
            mode_q  <= lane_mode_e'(mode_in);
        end else if (at_end) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            slot_q  <= '0;
        end else if (busy_q) begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // Sticky overrun flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (drop) begin
            ovr_q <= 1'b1;
        end
    end

    assign load_o    = accept;
    assign shift_o   = busy_q && phase_q && !at_end;
    assign active_o  = busy_q;
    assign lanes_o   = lanes_of(mode_q);
    assign dclk_o    = busy_q && phase_q;
    assign frame_o   = busy_q && (slot_q < half_slot);
    assign overrun_o = ovr_q;

    // R9: once set, the overrun flag never clears without reset.
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q)
        else $error("overrun flag cleared without reset");

    // R9: a dropped strobe must not restart the word in flight.
    p_drop_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (busy_q && (phase_q || slot_q != '0)))
        else $error("dropped sample restarted the word");

    // R7: the captured mode holds for the whole word.
    p_mode_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !at_end) |=> $stable(mode_q))
        else $error("lane mode changed inside a word");

    // R6: the data clock stays low while idle.
    p_dclk_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !dclk_o)
        else $error("data clock toggled while idle");

    // R5: the frame is high in the first cycle of every accepted word.
    p_frame_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> frame_o)
        else $error("frame low at word start");

endmodule

// File: rtl/lser_channel.sv
// Module: lser_channel
// Per-channel shift register. It loads a word on acceptance and, at each
// slot end, moves it left by the active lane count so that the MSB-side bits
// always sit on the lanes. Lanes above the active count are forced to 0.
// Assumes LANES is 4 and the lane count is 1, 2 or 4.
module lser_channel #(
    parameter int WORD_W = 16,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              active_i,
    input  logic [2:0]        lanes_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [LANES-1:0]  lane_o
);

    logic [WORD_W-1:0] sreg_q;

    // Word load and per-slot shift by the active lane count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load_i) begin
            sreg_q <= word_i;
        end else if (shift_i) begin
            case (lanes_i)
                3'd4:    sreg_q <= sreg_q << 4;
                3'd2:    sreg_q <= sreg_q << 2;
                default: sreg_q <= sreg_q << 1;
            endcase
        end
    end

    // Lane j carries the j-th bit below the MSB while it is an active lane.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_o[j] = active_i && (3'(j) < lanes_i) && sreg_q[WORD_W-1-j];
    end

    // R4: in one-lane mode only lane A may be driven.
    p_unused_lanes_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lanes_i == 3'd1) |-> (lane_o[LANES-1:1] == '0))
        else $error("unused lane driven in one-lane mode");

    // R4: all lanes are quiet while idle.
    p_idle_lanes_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> (lane_o == '0))
        else $error("lane driven while idle");

endmodule

// File: rtl/dual_lane_serializer.sv
// Module: dual_lane_serializer (top)
// Serializes NUM_CH simultaneously captured words onto LANES lanes each,
// with a shared forwarded data clock and frame marker. One sequencer drives
// all channel shifters, so all channels stay slot-aligned.
// Assumes WORD_W is a multiple of 4 and LANES is 4.
module dual_lane_serializer #(
    parameter int WORD_W = 16,
    parameter int NUM_CH = 2,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_valid,
    input  logic [NUM_CH*WORD_W-1:0]  smp_words,
    input  logic [1:0]                lane_mode,
    output logic [NUM_CH*LANES-1:0]   lanes_out,
    output logic                      dclk_out,
    output logic                      frame_out,
    output logic                      overrun
);

    logic       load;
    logic       shift;
    logic       active;
    logic [2:0] lane_cnt;

    lser_sequencer #(
        .WORD_W (WORD_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .mode_in   (lane_mode),
        .load_o    (load),
        .shift_o   (shift),
        .active_o  (active),
        .lanes_o   (lane_cnt),
        .dclk_o    (dclk_out),
        .frame_o   (frame_out),
        .overrun_o (overrun)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        lser_channel #(
            .WORD_W (WORD_W),
            .LANES  (LANES)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load),
            .shift_i  (shift),
            .active_i (active),
            .lanes_i  (lane_cnt),
            .word_i   (smp_words[c*WORD_W +: WORD_W]),
            .lane_o   (lanes_out[c*LANES +: LANES])
        );
    end

    // R6: the data clock only toggles while a word is active.
    p_dclk_only_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_out |-> active)
        else $error("data clock high while idle");

endmodule

// File: tb/dual_lane_serializer_tb.sv
`timescale 1ns/1ps
module dual_lane_serializer_tb_top;

    localparam int W   = 16;
    localparam int NCH = 2;
    localparam int NL  = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             smp_valid;
    logic [NCH*W-1:0] smp_words;
    logic [1:0]       lane_mode;
    logic [NCH*NL-1:0] lanes_out;
    logic             dclk_out;
    logic             frame_out;
    logic             overrun;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;
    bit exp_ovr = 1'b0;

    always #2.5 clk = ~clk;

    dual_lane_serializer #(.WORD_W(W), .NUM_CH(NCH), .LANES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_words(smp_words),
        .lane_mode(lane_mode), .lanes_out(lanes_out), .dclk_out(dclk_out),
        .frame_out(frame_out), .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lanes_for(input logic [1:0] m);
        case (m)
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [NL-1:0] exp_lanes(input logic [W-1:0] w, input int l, input int k);
        logic [NL-1:0] r = '0;
        for (int j = 0; j < NL; j++) begin
            if (j < l) r[j] = w[W-1-l*k-j];
        end
        return r;
    endfunction

    // Offer a pair to an idle block; returns at the negedge after acceptance.
    task automatic start(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] m);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_words = {b, a};
        lane_mode = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Check one word cycle by cycle; optionally disturb mode, inject a strobe,
    // or chain the next word in the last cycle.
    task automatic run_word(input logic [W-1:0] a, input logic [W-1:0] b, input int l,
                            input bit chain_in, input int mchg, input int inj,
                            input bit chain_out, input logic [W-1:0] na,
                            input logic [W-1:0] nb, input logic [1:0] nm);
        int n = W / l;
        for (int c = 0; c < 2*n; c++) begin
            int k = c / 2;
            string tag;
            if (c == 0) tag = "R2 first slot";
            else if (mchg >= 0) tag = "R7 lanes after mode change";
            else if (chain_in) tag = "R8 chained word lanes";
            else tag = "R3 lanes";
            chk(tag, int'(lanes_out[NL-1:0]), int'(exp_lanes(a, l, k)));
            chk(tag, int'(lanes_out[2*NL-1:NL]), int'(exp_lanes(b, l, k)));
            if (l < NL) chk("R4 unused lanes", int'(lanes_out[NL-1:0] >> l), 0);
            chk("R5 frame", int'(frame_out), (k < n/2) ? 1 : 0);
            chk("R6 dclk", int'(dclk_out), c % 2);
            chk("R9 overrun", int'(overrun), int'(exp_ovr));
            smp_valid = 1'b0;
            if (c == mchg) lane_mode = 2'($urandom);
            if (c == inj) begin
                smp_valid = 1'b1;
                smp_words = {$urandom, $urandom};
            end
            if (c == 2*n-1 && chain_out) begin
                smp_valid = 1'b1;
                smp_words = {nb, na};
                lane_mode = nm;
            end
            @(posedge clk);
            if (c == inj && c != 2*n-1) exp_ovr = 1'b1;
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    task automatic idle_check(input int cyc);
        smp_valid = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            chk("R4 idle lanes", int'(lanes_out), 0);
            chk("R5 idle frame", int'(frame_out), 0);
            chk("R6 idle dclk", int'(dclk_out), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ca, cb, na, nb;
        logic [1:0]   cm, nm;
        bit           chain;
        int           inj, mchg, n;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        smp_valid = 1'b0;
        smp_words = '0;
        lane_mode = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset lanes", int'(lanes_out), 0);
        chk("R1 reset frame", int'(frame_out), 0);
        chk("R1 reset dclk", int'(dclk_out), 0);
        chk("R1 reset overrun", int'(overrun), 0);
        rst_n = 1'b1;
        idle_check(2);

        // Directed: each mode code, with distinctive bit patterns.
        start(16'h8001, 16'h7FFE, 2'b00);
        run_word(16'h8001, 16'h7FFE, 1, 0, -1, -1, 0, 0, 0, 0);
        idle_check(2);
        start(16'hA5C3, 16'h5A3C, 2'b01);
        run_word(16'hA5C3, 16'h5A3C, 2, 0, -1, -1, 0, 0, 0, 0);
        idle_check(2);
        start(16'h1234, 16'hFEDC, 2'b10);
        run_word(16'h1234, 16'hFEDC, 4, 0, -1, -1, 0, 0, 0, 0);
        idle_check(2);
        start(16'hC001, 16'h0003, 2'b11);
        run_word(16'hC001, 16'h0003, 1, 0, -1, -1, 0, 0, 0, 0);
        idle_check(1);

        // Directed R8: four-lane word chained into a one-lane word.
        start(16'hF00F, 16'h0FF0, 2'b10);
        run_word(16'hF00F, 16'h0FF0, 4, 0, -1, -1, 1, 16'h9669, 16'h6996, 2'b00);
        run_word(16'h9669, 16'h6996, 1, 1, -1, -1, 0, 0, 0, 0);
        idle_check(1);

        // Directed R7 then R9: mode change, then dropped strobe mid-word.
        start(16'hBEEF, 16'hCAFE, 2'b01);
        run_word(16'hBEEF, 16'hCAFE, 2, 0, 3, -1, 0, 0, 0, 0);
        idle_check(1);
        start(16'h0F1E, 16'hE1F0, 2'b10);
        run_word(16'h0F1E, 16'hE1F0, 4, 0, -1, 2, 0, 0, 0, 0);
        idle_check(2);

        // Random words with random chaining, mode changes and drops.
        ca = 16'($urandom); cb = 16'($urandom); cm = 2'($urandom);
        start(ca, cb, cm);
        chain = 1'b0;
        for (int i = 0; i < 40; i++) begin
            bit prev_chain = chain;
            n = W / lanes_for(cm);
            na = 16'($urandom); nb = 16'($urandom); nm = 2'($urandom);
            chain = ($urandom % 2) == 0;
            inj  = (($urandom % 4) == 0) ? int'($urandom % (2*n-1)) : -1;
            mchg = (($urandom % 3) == 0) ? int'($urandom % (2*n)) : -1;
            run_word(ca, cb, lanes_for(cm), prev_chain, mchg, inj, chain, na, nb, nm);
            if (!chain) begin
                idle_check(2);
                start(na, nb, nm);
            end
            ca = na; cb = nb; cm = nm;
        end
        run_word(ca, cb, lanes_for(cm), chain, -1, -1, 0, 0, 0, 0);
        idle_check(1);

        // R9 / R1: overrun clears only through reset.
        chk("R9 overrun still set", int'(overrun), int'(exp_ovr));
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        exp_ovr = 1'b0;
        chk("R1 overrun cleared by reset", int'(overrun), 0);
        chk("R1 lanes after reset", int'(lanes_out), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule